// File: doc/BRIEF.md
# Reference Divider with Selectable Ratio and Clock Output Select

This block divides the reference oscillator clock down to the clock used by a phase comparator. A 5-bit select code picks one of 29 legal divide ratios. Every legal ratio is a base value of 2, 5, 6 or 7 multiplied by a power of two. The two upper code bits choose the base, and the three lower bits choose the shift. Three codes are illegal. When one of them is presented, a flag is raised and the block keeps dividing by the last legal ratio. A new ratio only takes effect when the current output period ends, so a change never produces a shortened or stretched pulse.

A second path feeds the pad that drives a companion synthesiser. Two registered controls decide what that pad carries: the undivided reference clock, the divided comparison clock, or nothing. In the last case the pad driver is switched off. Both controls come out of reset set, so the comparison clock is driven from power-up.

Top module: `ref_ratio_divider`

## Requirements
- R1: With select bits [4:3] = 00, select bits [2:0] = k (0..7) give a divide ratio of 2 shifted left by k: 2, 4, 8 and so on up to 256.
- R2: With select bits [4:3] = 01, 10 or 11, the base is 5, 6 or 7 respectively. Select bits [2:0] = k (1..7) give that base shifted left by k-1, so the ratios run from 5 to 320, from 6 to 384, and from 7 to 448.
- R3: Codes 01000, 10000 and 11000 are illegal. The output `code_bad` is 1 on the clock edge after such a code is applied, and 0 on the clock edge after a legal code is applied.
- R4: While an illegal code is applied, the comparison clock keeps the period of the last legal ratio.
- R5: A ratio change takes effect only at a period boundary. Every comparison-clock period equals either the old ratio or the new one, and every period that starts at least one full period after the change equals the new ratio.
- R6: Each comparison-clock period of N reference cycles starts with a rising edge. The clock is high for floor(N/2) cycles and low for the rest.
- R7: When the registered enable is 0, `pin_drive` is 0 and `pin_out` is 0.
- R8: When the registered enable is 1, `pin_out` follows the reference clock if the registered pick is 0, and follows `cmp_clk` if the registered pick is 1.
- R9: During reset, `cmp_clk` is 0, `code_bad` is 0, and both the enable and the pick are held at 1 whatever their inputs are. The ratio resets to 2.
- R10: `pin_en` and `pin_pick` take effect one reference-clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 5 | Divide-ratio select code |
| pin_en | input | 1 | Enables the output pad driver (1 = drive) |
| pin_pick | input | 1 | Output pad source: 0 = reference clock, 1 = comparison clock |
| cmp_clk | output | 1 | Comparison clock (the divided reference clock) |
| code_bad | output | 1 | Set while the registered select code is illegal |
| pin_out | output | 1 | Data to the output pad |
| pin_drive | output | 1 | Output pad enable; 0 means high impedance |

## Verification
Each result has a fixed latency, and every check is timed to it.

- **Illegal flag and output controls.** These are registered once, so the bench drives them just after a falling edge and checks at the very next falling edge.
- **Comparison clock.** The bench samples `cmp_clk` on falling edges. It measures each period from one rising edge to the next, counting high samples along the way.
- **Ratio changes.** After a code change, the first complete period may belong to either ratio (R5). Only the second complete period is compared with the exact ratio and high time. The expected ratio is computed in the bench as the base multiplied by a power of two.
- **Reference clock on the pad.** This is checked at both clock phases: a quarter period after the rising edge, and at the falling edge.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int CODE_W    = 5;
    localparam int MAX_RATIO = 448;
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef logic [CNT_W-1:0]  ratio_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        FAM_TWO   = 2'd0,
        FAM_FIVE  = 2'd1,
        FAM_SIX   = 2'd2,
        FAM_SEVEN = 2'd3
    } family_e;

    typedef struct packed {
        logic   bad;
        ratio_t ratio;
    } decode_t;

    function automatic decode_t decode_code(input code_t code);
        decode_t  d;
        family_e  fam;
        logic [2:0] k;
        ratio_t   base;
        fam = family_e'(code[4:3]);
        k   = code[2:0];
        case (fam)
            FAM_TWO:   base = ratio_t'(2);
            FAM_FIVE:  base = ratio_t'(5);
            FAM_SIX:   base = ratio_t'(6);
            default:   base = ratio_t'(7);
        endcase
        d.bad = 1'b0;
        if (fam == FAM_TWO) begin
            d.ratio = base << k;
        end else if (k == 3'd0) begin
            d.bad   = 1'b1;
            d.ratio = '0;
        end else begin
            d.ratio = base << (k - 3'd1);
        end
        return d;
    endfunction
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  code_t  code,
    output ratio_t pend_ratio,
    output logic   bad
);
    localparam ratio_t RST_RATIO = decode_code(RST_CODE).ratio;

    decode_t dec;
    always_comb dec = decode_code(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            bad        <= 1'b0;
            pend_ratio <= RST_RATIO;
        end else begin
            bad <= dec.bad;
            if (!dec.bad) pend_ratio <= dec.ratio;
        end
    end

    // R3
    illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (code[2:0] == 3'd0 && code[4:3] != 2'd0) |=> bad);

    // R4
    hold_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (code[2:0] == 3'd0 && code[4:3] != 2'd0) |=> $stable(pend_ratio));
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
#(
    parameter ratio_t RST_RATIO = ratio_t'(2)
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_t pend_ratio,
    output logic   div_clk
);
    ratio_t cnt, act;
    ratio_t cnt_nx, n_eff;
    logic   wrap, hi_nx;

    always_comb begin
        wrap   = (cnt == '0);
        n_eff  = wrap ? pend_ratio : act;
        cnt_nx = wrap ? (pend_ratio - ratio_t'(1)) : (cnt - ratio_t'(1));
        hi_nx  = (cnt_nx >= (n_eff - (n_eff >> 1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act     <= RST_RATIO;
            div_clk <= 1'b0;
        end else begin
            cnt     <= cnt_nx;
            div_clk <= hi_nx;
            if (wrap) act <= pend_ratio;
        end
    end

    // R5
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(act));

    // R6
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < act);
endmodule

// File: rtl/refdiv_outmux.sv
module refdiv_outmux (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pick,
    input  logic div_clk,
    output logic pad_out,
    output logic pad_drive
);
    logic en_q, pick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b1;
            pick_q <= 1'b1;
        end else begin
            en_q   <= en;
            pick_q <= pick;
        end
    end

    always_comb begin
        pad_drive = en_q;
        pad_out   = en_q & (pick_q ? div_clk : clk);
    end

    // R7
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pad_drive |-> !pad_out);

    // R10
    enable_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pad_drive == $past(en)));
endmodule

// File: rtl/ref_ratio_divider.sv
module ref_ratio_divider
    import refdiv_pkg::*;
#(
    parameter code_t RST_CODE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic             pin_en,
    input  logic             pin_pick,
    output logic             cmp_clk,
    output logic             code_bad,
    output logic             pin_out,
    output logic             pin_drive
);
    localparam ratio_t RST_RATIO = decode_code(RST_CODE).ratio;

    ratio_t pend_ratio;

    refdiv_decode #(.RST_CODE(RST_CODE)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .code       (ratio_code),
        .pend_ratio (pend_ratio),
        .bad        (code_bad)
    );

    refdiv_counter #(.RST_RATIO(RST_RATIO)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .pend_ratio (pend_ratio),
        .div_clk    (cmp_clk)
    );

    refdiv_outmux u_mux (
        .clk       (clk),
        .rst       (rst),
        .en        (pin_en),
        .pick      (pin_pick),
        .div_clk   (cmp_clk),
        .pad_out   (pin_out),
        .pad_drive (pin_drive)
    );

    // R9
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cmp_clk && !code_bad && pin_drive));
endmodule

// File: tb/sim_ref_ratio_divider.sv
module sim_ref_ratio_divider;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ratio_code = 5'd0;
    logic       pin_en = 1'b0;
    logic       pin_pick = 1'b0;
    logic       cmp_clk, code_bad, pin_out, pin_drive;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ref_ratio_divider u0 (
        .clk(clk), .rst(rst), .ratio_code(ratio_code),
        .pin_en(pin_en), .pin_pick(pin_pick),
        .cmp_clk(cmp_clk), .code_bad(code_bad),
        .pin_out(pin_out), .pin_drive(pin_drive)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // expected ratio: base times a power of two; 0 for an illegal code
    function automatic int exp_ratio(input logic [4:0] c);
        int base;
        int k;
        k = int'(c[2:0]);
        case (c[4:3])
            2'd0: base = 2;
            2'd1: base = 5;
            2'd2: base = 6;
            default: base = 7;
        endcase
        if (c[4:3] == 2'd0) return base * (2 ** k);
        if (k == 0) return 0;
        return base * (2 ** (k - 1));
    endfunction

    task automatic next_rise();
        do @(negedge clk); while (cmp_clk);
        do @(negedge clk); while (!cmp_clk);
    endtask

    // called at a sample where cmp_clk has just risen; returns at the next rise
    task automatic measure(output int per, output int hi);
        logic seen_low;
        per = 0;
        hi = 0;
        seen_low = 1'b0;
        forever begin
            if (cmp_clk) hi++;
            per++;
            @(negedge clk);
            if (!cmp_clk) seen_low = 1'b1;
            if (cmp_clk && seen_low) break;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int per, hi, prev_r, r;
        // reset with controls driven low and an illegal code applied
        ratio_code = 5'b01000;
        pin_en = 1'b0;
        pin_pick = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 reset cmp_clk", int'(cmp_clk), 0);
        check("R9 reset code_bad", int'(code_bad), 0);
        check("R9 reset pin_drive", int'(pin_drive), 1);
        check("R9 reset pin_out", int'(pin_out), 0);
        pin_en = 1'b1;
        pin_pick = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        check("R3 illegal after reset", int'(code_bad), 1);
        next_rise();
        measure(per, hi);
        measure(per, hi);
        check("R9 default ratio 2", per, 2);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 default pick comp", int'(pin_out), int'(cmp_clk));
        end

        prev_r = 2;
        for (int c = 0; c < 32; c++) begin
            ratio_code = 5'(c);
            r = exp_ratio(5'(c));
            @(negedge clk);
            check(r == 0 ? "R3 illegal flag set" : "R3 legal flag clear",
                  int'(code_bad), r == 0 ? 1 : 0);
            next_rise();
            measure(per, hi);
            n_checks++;
            if (per != prev_r && per != (r == 0 ? prev_r : r)) begin
                n_errors++;
                $display("FAIL R5 code %0d: got %0d expected %0d or %0d",
                         c, per, prev_r, r);
            end
            measure(per, hi);
            if (r == 0) begin
                check("R4 held ratio", per, prev_r);
            end else begin
                check(c < 8 ? "R1 ratio" : "R2 ratio", per, r);
                check("R6 high time", hi, r / 2);
                prev_r = r;
            end
        end

        // output pad selection
        ratio_code = 5'd1;
        repeat (20) @(negedge clk);
        pin_en = 1'b0;
        @(negedge clk);
        check("R7 R10 drive off", int'(pin_drive), 0);
        check("R7 out low", int'(pin_out), 0);
        @(posedge clk);
        #(CLK_P/4);
        check("R7 out low clk high", int'(pin_out), 0);
        @(negedge clk);
        pin_en = 1'b1;
        pin_pick = 1'b0;
        @(negedge clk);
        check("R10 drive on", int'(pin_drive), 1);
        check("R8 ref low phase", int'(pin_out), 0);
        @(posedge clk);
        #(CLK_P/4);
        check("R8 ref high phase", int'(pin_out), 1);
        @(negedge clk);
        pin_pick = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check("R8 comp on pad", int'(pin_out), int'(cmp_clk));
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule